// File: doc/BRIEF.md
# Simultaneous Feeder Fault Detector

This block watches the time-overcurrent pickup flags of a group of feeders and trips quickly only when two or more of them are faulted at the same moment. In that situation the transformer low-voltage backup relay sees the sum of all the fault currents, so it may operate before the slower feeder relays do. The block lets a faulted feeder clear on its own trip output before the backup relay can open the whole bus. A feeder counts as faulted when either its phase pickup or its ground pickup is set. A faulted feeder is "declared" while at least one other feeder is faulted too.

Each feeder has its own timer. The timer counts power-cycle ticks (`cyc_tick_i`, one clock wide per power cycle) while its feeder stays declared. When the count reaches the security delay, the feeder's trip output goes high. On the same clock the block pulses that feeder's reclose-initiate output for one clock. A shared alarm stays high while any feeder is tripped. When the declaration clears, the trip is held for a settable dropout time, also counted in ticks, and then released. The overcurrent curves themselves and the reclosing sequence belong to other blocks.

Each feeder runs its own state machine:
- States: `ST_IDLE` (no declaration), `ST_ARM` (declared, counting ticks towards the delay), `ST_TRIP` (tripped and still declared) and `ST_HOLD` (tripped, declaration gone, counting the dropout).
- Transitions:
  - arm: `ST_IDLE`→`ST_ARM` when the feeder becomes declared.
  - abort: `ST_ARM`→`ST_IDLE` when the declaration is lost.
  - fire: `ST_ARM`→`ST_TRIP` on the tick that completes the delay.
  - fast fire: `ST_IDLE`→`ST_TRIP` only when the delay is one tick.
  - release: `ST_TRIP`→`ST_HOLD` when the declaration clears.
  - re-assert: `ST_HOLD`→`ST_TRIP` when the feeder is declared again.
  - drop: `ST_HOLD`→`ST_IDLE` on the tick that completes the dropout.
  - fast drop: `ST_TRIP`→`ST_IDLE` only when the dropout is one tick.

Top module: `simfault_guard`

## Requirements
- R1: Feeder i is faulted when `phase_pu_i[i]` OR `gnd_pu_i[i]` is 1. Either flag alone counts the same as both together.
- R2: A fault on one feeder alone, with no other feeder faulted, never sets any trip, reclose or alarm output, however long it lasts.
- R3: Feeder i is declared while it is faulted and at least one other feeder is faulted. Its trip output `trip_o[i]` goes to 1 on the clock edge that samples the DELAY_TICKS-th tick (default 3) counted while the feeder has been declared without a break. A tick sampled in the first declared cycle counts.
- R4: Trip outputs go high only for feeders that are declared. Bit i of every output vector belongs to feeder i, and a feeder that is not involved stays at 0.
- R5: `reclose_o[i]` is 1 for exactly one clock, on the same clock as the rising edge of `trip_o[i]`. At every other time it is 0.
- R6: `alarm_o` is 1 exactly while at least one bit of `trip_o` is 1.
- R7: After a tripped feeder loses its declaration, its trip stays at 1 until the edge that samples the DROPOUT_TICKS-th tick since then (default 1). If the feeder is declared again before that edge, the trip stays at 1 without a new reclose pulse.
- R8: If the declaration is lost before the delay completes, no trip is issued. A later declaration starts the count again from zero.
- R9: While `rst_n` is 0, all outputs are 0 and every timer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick_i | input | 1 | One-clock pulse once per power cycle |
| phase_pu_i | input | NUM_FEEDERS | Phase time-overcurrent pickup, one bit per feeder |
| gnd_pu_i | input | NUM_FEEDERS | Ground time-overcurrent pickup, one bit per feeder |
| trip_o | output | NUM_FEEDERS | Fast trip, one bit per feeder |
| reclose_o | output | NUM_FEEDERS | Reclose-initiate pulse, one bit per feeder |
| alarm_o | output | 1 | Simultaneous-fault alarm |

## Verification
The directed patterns each separate one pair of behaviours:
- A lone faulted feeder held for many ticks tells coincidence detection apart from a plain overcurrent trip.
- A ground pickup on one feeder with a phase pickup on another shows that the two flags are merged.
- A pair held for two ticks and then for three ticks places the delay boundary exactly.
- A three-feeder fault with a fourth feeder idle shows that only the involved feeders are tripped.
- Clearing a pair and then faulting it again during the dropout separates the hold from a fresh trip, and shows whether a second reclose pulse is sent.

A long stretch of random pickups and ticks is then compared clock by clock against a counter-based model in the bench.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_TRIP = 2'd2,
        ST_HOLD = 2'd3
    } fdr_state_t;

    function automatic logic is_tripping(input fdr_state_t s);
        return (s == ST_TRIP) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/sfd_coincidence.sv
module sfd_coincidence #(
    parameter int NUM_FEEDERS = 4
) (
    input  logic [NUM_FEEDERS-1:0] phase_pu_i,
    input  logic [NUM_FEEDERS-1:0] gnd_pu_i,
    output logic [NUM_FEEDERS-1:0] fault_o,
    output logic [NUM_FEEDERS-1:0] decl_o
);

    // R1: a feeder is faulted when either of its pickups is set
    assign fault_o = phase_pu_i | gnd_pu_i;

    for (genvar g = 0; g < NUM_FEEDERS; g++) begin : g_decl
        logic [NUM_FEEDERS-1:0] others;

        always_comb begin
            others    = fault_o;
            others[g] = 1'b0;
        end

        assign decl_o[g] = fault_o[g] && (others != '0);
    end

    // a_r2_lone_fault: a single faulted feeder is never declared
    always_comb begin
        if ($onehot0(phase_pu_i | gnd_pu_i)) begin
            a_r2_lone_fault: assert (decl_o == '0);
        end
    end

    // a_r4_decl_subset: only faulted feeders can be declared
    always_comb begin
        a_r4_decl_subset: assert ((decl_o & ~(phase_pu_i | gnd_pu_i)) == '0);
    end

endmodule

// File: rtl/sfd_feeder_fsm.sv
module sfd_feeder_fsm
    import sfd_pkg::*;
#(
    parameter int DELAY_TICKS   = 3,
    parameter int DROPOUT_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic decl_i,
    output logic trip_o,
    output logic rcl_o
);

    localparam int MAX_TICKS = (DELAY_TICKS > DROPOUT_TICKS) ? DELAY_TICKS : DROPOUT_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_TICKS - 1);
    localparam logic [CW-1:0] DRP_LAST = CW'(DROPOUT_TICKS - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    fdr_state_t    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          trip_q, rcl_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (decl_i) begin
                    if (tick_i && (DELAY_TICKS == 1)) begin
                        state_n = ST_TRIP;
                        cnt_n   = '0;
                    end else begin
                        state_n = ST_ARM;
                        cnt_n   = tick_i ? CNT_ONE : '0;
                    end
                end else begin
                    cnt_n = '0;
                end
            end
            ST_ARM: begin
                if (!decl_i) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else if (tick_i) begin
                    if (cnt_q == DLY_LAST) begin
                        state_n = ST_TRIP;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + CNT_ONE;
                    end
                end
            end
            ST_TRIP: begin
                if (!decl_i) begin
                    if (tick_i && (DROPOUT_TICKS == 1)) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end else begin
                        state_n = ST_HOLD;
                        cnt_n   = tick_i ? CNT_ONE : '0;
                    end
                end else begin
                    cnt_n = '0;
                end
            end
            ST_HOLD: begin
                if (decl_i) begin
                    state_n = ST_TRIP;
                    cnt_n   = '0;
                end else if (tick_i) begin
                    if (cnt_q == DRP_LAST) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + CNT_ONE;
                    end
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_q <= 1'b0;
            rcl_q  <= 1'b0;
        end else begin
            trip_q <= is_tripping(state_n);
            rcl_q  <= is_tripping(state_n) && !is_tripping(state_q);
        end
    end

    assign trip_o = trip_q;
    assign rcl_o  = rcl_q;

    // R3: a trip only rises on a tick sampled while declared
    a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> ($past(decl_i) && $past(tick_i)));

    // R5: reclose is a single-clock pulse aligned with the trip edge
    a_r5_rcl_single: assert property (@(posedge clk) disable iff (!rst_n)
        rcl_o |=> !rcl_o);

    a_r5_rcl_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rcl_o |-> (trip_o && !$past(trip_o)));

    // R7: a trip only falls on a tick sampled without declaration
    a_r7_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trip_o) |-> ($past(tick_i) && !$past(decl_i)));

    // R8: the arming count never reaches the delay
    a_r8_arm_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |-> (int'(cnt_q) < DELAY_TICKS));

endmodule

// File: rtl/simfault_guard.sv
module simfault_guard #(
    parameter int NUM_FEEDERS   = 4,
    parameter int DELAY_TICKS   = 3,
    parameter int DROPOUT_TICKS = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cyc_tick_i,
    input  logic [NUM_FEEDERS-1:0] phase_pu_i,
    input  logic [NUM_FEEDERS-1:0] gnd_pu_i,
    output logic [NUM_FEEDERS-1:0] trip_o,
    output logic [NUM_FEEDERS-1:0] reclose_o,
    output logic                   alarm_o
);

    logic [NUM_FEEDERS-1:0] fault;
    logic [NUM_FEEDERS-1:0] decl;

    sfd_coincidence #(
        .NUM_FEEDERS(NUM_FEEDERS)
    ) u_coinc (
        .phase_pu_i(phase_pu_i),
        .gnd_pu_i  (gnd_pu_i),
        .fault_o   (fault),
        .decl_o    (decl)
    );

    for (genvar g = 0; g < NUM_FEEDERS; g++) begin : g_fdr
        sfd_feeder_fsm #(
            .DELAY_TICKS  (DELAY_TICKS),
            .DROPOUT_TICKS(DROPOUT_TICKS)
        ) u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .tick_i(cyc_tick_i),
            .decl_i(decl[g]),
            .trip_o(trip_o[g]),
            .rcl_o (reclose_o[g])
        );
    end

    assign alarm_o = |trip_o;

    // R6: the alarm can only come up after two feeders were faulted together
    a_r6_alarm_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> ($countones($past(fault)) >= 2));

    // R4: a reclose pulse is issued only for a feeder that was declared
    a_r4_rcl_declared: assert property (@(posedge clk) disable iff (!rst_n)
        ((reclose_o & ~$past(decl)) == '0));

endmodule

// File: tb/simfault_guard_tb_top.sv
module simfault_guard_tb_top;

    localparam int N     = 4;
    localparam int DLY   = 3;
    localparam int DRP   = 1;
    localparam int WDOG  = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [N-1:0] ph = '0;
    logic [N-1:0] gd = '0;
    logic [N-1:0] trip, rcl;
    logic         alarm;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    simfault_guard #(
        .NUM_FEEDERS  (N),
        .DELAY_TICKS  (DLY),
        .DROPOUT_TICKS(DRP)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_tick_i(tick),
        .phase_pu_i(ph),
        .gnd_pu_i  (gd),
        .trip_o    (trip),
        .reclose_o (rcl),
        .alarm_o   (alarm)
    );

    // behavioural reference model
    int           acnt[N];
    int           dcnt[N];
    logic [N-1:0] m_trip = '0;
    logic [N-1:0] m_rcl  = '0;

    always @(posedge clk) begin
        logic [N-1:0] flt;
        int           nflt;
        logic [N-1:0] old;
        cycles++;
        old  = m_trip;
        flt  = ph | gd;
        nflt = $countones(flt);
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                acnt[i] = 0;
                dcnt[i] = 0;
            end
            m_trip = '0;
            m_rcl  = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit dec;
                dec = flt[i] && (nflt >= 2);
                if (!m_trip[i]) begin
                    if (dec) begin
                        acnt[i] += int'(tick);
                        if (acnt[i] >= DLY) begin
                            m_trip[i] = 1'b1;
                            dcnt[i]   = 0;
                        end
                    end else begin
                        acnt[i] = 0;
                    end
                end else begin
                    if (dec) begin
                        dcnt[i] = 0;
                    end else begin
                        dcnt[i] += int'(tick);
                        if (dcnt[i] >= DRP) begin
                            m_trip[i] = 1'b0;
                            acnt[i]   = 0;
                        end
                    end
                end
            end
            m_rcl = m_trip & ~old;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (trip !== m_trip) begin
                fails++;
                $display("FAIL R3 trip model mismatch: actual %b expected %b", trip, m_trip);
            end
            if (rcl !== m_rcl) begin
                fails++;
                $display("FAIL R5 reclose model mismatch: actual %b expected %b", rcl, m_rcl);
            end
            if (alarm !== (|m_trip)) begin
                fails++;
                $display("FAIL R6 alarm model mismatch: actual %b expected %b", alarm, |m_trip);
            end
        end
    end

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one clock, with or without a tick; starts and ends at a falling edge
    task automatic step(input logic t);
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic hold_ticks(input int k);
        for (int j = 0; j < k; j++) begin
            step(1'b0);
            step(1'b0);
            step(1'b0);
            step(1'b1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        step(1'b1);
        step(1'b0);
        // R9: outputs held low in reset
        chk("R9 reset trip", trip, '0);
        chk("R9 reset reclose", rcl, '0);
        chk("R9 reset alarm", {3'b000, alarm}, '0);
        rst_n = 1'b1;
        step(1'b0);

        // R2: a lone feeder fault never trips
        ph = 4'b0001;
        hold_ticks(6);
        chk("R2 lone fault trip", trip, '0);
        chk("R2 lone fault alarm", {3'b000, alarm}, '0);
        ph = '0;
        hold_ticks(1);

        // R8: a pair held for only two ticks gives no trip
        ph = 4'b0011;
        hold_ticks(2);
        chk("R8 short pair trip", trip, '0);
        ph = 4'b0001;
        step(1'b0);
        ph = 4'b0011;
        hold_ticks(2);
        chk("R8 restart from zero", trip, '0);
        step(1'b0);

        // R3: the third tick completes the delay
        hold_ticks(1);
        chk("R3 pair tripped", trip, 4'b0011);
        chk("R5 reclose pulse", rcl, 4'b0011);
        chk("R6 alarm up", {3'b000, alarm}, 4'b0001);
        step(1'b0);
        chk("R5 reclose single clock", rcl, '0);

        // R7: dropout holds the trip until the next tick
        ph = '0;
        step(1'b0);
        chk("R7 trip held in dropout", trip, 4'b0011);
        ph = 4'b0011;
        step(1'b0);
        chk("R7 re-declared keeps trip", trip, 4'b0011);
        chk("R7 no second reclose", rcl, '0);
        ph = '0;
        step(1'b0);
        step(1'b1);
        chk("R7 trip released", trip, '0);
        chk("R6 alarm down", {3'b000, alarm}, '0);
        hold_ticks(1);

        // R1: a ground pickup merges with a phase pickup
        gd = 4'b0100;
        ph = 4'b1000;
        hold_ticks(3);
        chk("R1 ground plus phase tripped", trip, 4'b1100);
        gd = '0;
        ph = '0;
        hold_ticks(2);

        // R4: three feeders faulted, the fourth untouched
        ph = 4'b0101;
        gd = 4'b0010;
        hold_ticks(3);
        chk("R4 only involved feeders", trip, 4'b0111);
        ph = '0;
        gd = '0;
        hold_ticks(2);

        // random pickups and ticks, compared every clock
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 15) == 0) ph[i] = ~ph[i];
                if ($urandom_range(0, 23) == 0) gd[i] = ~gd[i];
            end
            step($urandom_range(0, 3) == 0);
        end
        ph = '0;
        gd = '0;
        hold_ticks(2);
        chk("R6 idle after random run", trip, '0);
        finish_run();
    end

    initial begin
        wait (cycles > WDOG);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WDOG);
            finish_run();
        end
    end

endmodule